// File: doc/BRIEF.md
# Paged Program Counter and Return Stack

This unit decides where a small microcontroller fetches next. It owns an 11-bit program counter and a three-level return-address stack. Each time `step` is high at a rising clock edge, the unit reads the current opcode byte, the byte that follows it and an indirect target byte. From these it loads the next program counter and, when the instruction calls for it, pushes or pops the stack.

Jumps within a page depend on where the counter already sits. Program memory is split into 64-word pages. On pages 2 and 3 a one-byte jump can reach any word of the 128-word region that holds both pages. On every other page it reaches only the current 64-word page, and the other half of that opcode range becomes a short call into page 2. Opcodes that transfer no control advance the counter by one. The unit has no program memory and no fetch sequencing of its own; the surrounding core supplies the bytes and the `step` strobe.

Top module: `pcu_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, all three stack levels and `skip_o` become 0.
- R2: A stepped opcode that is none of the transfers below sets the counter to its old value plus one, modulo 2048, so 0x7FF advances to 0x000. The stack is left unchanged.
- R3: When `step` is low, the counter, the stack and `skip_o` keep their values.
- R4: An opcode of the form 0110_0xyz loads the counter with {xyz, second byte}. The stack is left unchanged.
- R5: An opcode of the form 0110_1xyz loads the same target as R4. It also pushes the old counter plus 2 (modulo 2048) into level 0, moves level 0 to level 1 and level 1 to level 2, and drops the old level 2.
- R6: When counter bits 10:7 equal 0001 (pages 2 and 3), an opcode 1aaaaaaa other than 0xFF replaces counter bits 6:0 with aaaaaaa. The stack is left unchanged.
- R7: On any other page, an opcode 11aaaaaa other than 0xFF replaces counter bits 5:0 with aaaaaa. The stack is left unchanged.
- R8: On those other pages, an opcode 10aaaaaa pushes the old counter plus 1 (with the same shift as R5) and loads the counter with 0x080 | aaaaaa.
- R9: Opcode 0x48 loads the counter from level 0, moves level 1 to level 0 and level 2 to level 1. Level 2 keeps its value.
- R10: Opcode 0x49 pops exactly as R9 does. It also sets `skip_o` high from the edge that takes it until the next stepped opcode.
- R11: Opcode 0xFF keeps counter bits 10:8 and loads bits 7:0 from `ind_byte` on every page. This takes priority over R6 and R7.
- R12: Any stepped opcode other than 0x49 leaves `skip_o` low after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Execute the presented opcode at this edge |
| op_first | input | 8 | Current opcode byte |
| op_second | input | 8 | Byte that follows the opcode |
| ind_byte | input | 8 | Indirect jump target low byte |
| pc_o | output | 11 | Program counter |
| skip_o | output | 1 | Next instruction is to be skipped |
| stack_o | output | 33 | Stack levels; level 0 in bits 10:0, level 1 in bits 21:11, level 2 in bits 32:22 |

## Verification
The bench targets the page boundaries of the in-page decode: 0x0FF on page 3, 0x100 on page 4 and 0x07F on page 1. A design that tested the wrong page bits there would jump to the wrong word, or would push where it should only jump. Opcode 0xFF is applied on pages 2 and 4 to catch a decoder that lets the in-page jump win. Four calls without a return check that the deepest level is dropped. Repeated returns check that level 2 is kept rather than cleared. A long call from 0x7FE checks that the return address wraps to 0x000. A return-and-skip followed by ordinary opcodes, and by idle cycles, checks that `skip_o` is set, held and cleared at the right edges.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int PC_W   = 11;
    localparam int BYTE_W = 8;
    localparam int HI_W   = PC_W - BYTE_W;

    localparam logic [BYTE_W-1:0] OP_RET   = 8'h48;
    localparam logic [BYTE_W-1:0] OP_RETSK = 8'h49;
    localparam logic [BYTE_W-1:0] OP_IND   = 8'hFF;

    typedef enum logic [2:0] {
        XF_SEQ,
        XF_LJMP,
        XF_LCALL,
        XF_PJMP,
        XF_PCALL,
        XF_RET,
        XF_RETSK,
        XF_IND
    } xfer_e;

    typedef struct packed {
        xfer_e             kind;
        logic [PC_W-1:0]   target;
        logic [PC_W-1:0]   ret_addr;
    } xfer_t;

    // Pages 2 and 3 share counter bits 10:7 = 0001.
    function automatic logic in_wide_page(input logic [PC_W-1:0] pc);
        return pc[PC_W-1:7] == 4'b0001;
    endfunction

    function automatic xfer_e classify(input logic [BYTE_W-1:0] op,
                                       input logic              wide);
        xfer_e k;
        if (op == OP_IND)                 k = XF_IND;
        else if (op == OP_RET)            k = XF_RET;
        else if (op == OP_RETSK)          k = XF_RETSK;
        else if (op[7:3] == 5'b01100)     k = XF_LJMP;
        else if (op[7:3] == 5'b01101)     k = XF_LCALL;
        else if (op[7] && wide)           k = XF_PJMP;
        else if (op[7] && op[6])          k = XF_PJMP;
        else if (op[7])                   k = XF_PCALL;
        else                              k = XF_SEQ;
        return k;
    endfunction

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [PC_W-1:0]   pc,
    input  logic [BYTE_W-1:0] op_a,
    input  logic [BYTE_W-1:0] op_b,
    input  logic [BYTE_W-1:0] ind,
    output xfer_t             xf
);
    logic wide;

    always_comb begin
        wide        = in_wide_page(pc);
        xf.kind     = classify(op_a, wide);
        xf.ret_addr = (xf.kind == XF_LCALL) ? pc + PC_W'(2) : pc + PC_W'(1);
        unique case (xf.kind)
            XF_LJMP, XF_LCALL: xf.target = {op_a[HI_W-1:0], op_b};
            XF_PJMP:   xf.target = wide ? {pc[PC_W-1:7], op_a[6:0]}
                                        : {pc[PC_W-1:6], op_a[5:0]};
            XF_PCALL:  xf.target = {4'b0001, 1'b0, op_a[5:0]};
            XF_IND:    xf.target = {pc[PC_W-1:BYTE_W], ind};
            default:   xf.target = pc + PC_W'(1);
        endcase
    end

endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
    parameter int DEPTH = 3,
    parameter int W     = 11
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               push_val,
    output logic [DEPTH-1:0][W-1:0]    lvl
);
    localparam int LAST = DEPTH - 1;

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        logic [W-1:0] from_above;
        logic [W-1:0] from_below;
        if (i == 0) begin : g_top
            assign from_above = push_val;
        end else begin : g_mid
            assign from_above = lvl[i-1];
        end
        if (i == LAST) begin : g_bot
            assign from_below = lvl[i];
        end else begin : g_inner
            assign from_below = lvl[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst)       lvl[i] <= '0;
            else if (push) lvl[i] <= from_above;
            else if (pop)  lvl[i] <= from_below;
        end
    end

endmodule

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
    import pcu_pkg::*;
#(
    parameter int STACK_DEPTH = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        step,
    input  logic [BYTE_W-1:0]           op_first,
    input  logic [BYTE_W-1:0]           op_second,
    input  logic [BYTE_W-1:0]           ind_byte,
    output logic [PC_W-1:0]             pc_o,
    output logic                        skip_o,
    output logic [STACK_DEPTH*PC_W-1:0] stack_o
);
    logic [PC_W-1:0]                    pc_q;
    logic [PC_W-1:0]                    pc_d;
    logic                               skip_q;
    logic [STACK_DEPTH-1:0][PC_W-1:0]   lvl;
    xfer_t                              xf;
    logic                               do_push;
    logic                               do_pop;

    pcu_decode u_dec (
        .pc   (pc_q),
        .op_a (op_first),
        .op_b (op_second),
        .ind  (ind_byte),
        .xf   (xf)
    );

    always_comb begin
        do_push = step && (xf.kind == XF_LCALL || xf.kind == XF_PCALL);
        do_pop  = step && (xf.kind == XF_RET   || xf.kind == XF_RETSK);
        unique case (xf.kind)
            XF_RET, XF_RETSK: pc_d = lvl[0];
            default:          pc_d = xf.target;
        endcase
    end

    pcu_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (do_push),
        .pop      (do_pop),
        .push_val (xf.ret_addr),
        .lvl      (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            skip_q <= 1'b0;
        end else if (step) begin
            pc_q   <= pc_d;
            skip_q <= (xf.kind == XF_RETSK);
        end
    end

    assign pc_o    = pc_q;
    assign skip_o  = skip_q;
    assign stack_o = lvl;

endmodule

// File: rtl/pcu_ctrl_chk.sv
module pcu_ctrl_chk
    import pcu_pkg::*;
#(
    parameter int STACK_DEPTH = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        step,
    input logic [BYTE_W-1:0]           op_first,
    input logic [BYTE_W-1:0]           op_second,
    input logic [BYTE_W-1:0]           ind_byte,
    input logic [PC_W-1:0]             pc_o,
    input logic                        skip_o,
    input logic [STACK_DEPTH*PC_W-1:0] stack_o
);
    logic [PC_W-1:0] top;
    assign top = stack_o[PC_W-1:0];

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(pc_o) && $stable(stack_o) && $stable(skip_o)));

    assert_long_jump_R4: assert property (@(posedge clk) disable iff (rst)
        (step && op_first[7:3] == 5'b01100)
        |=> pc_o == {$past(op_first[2:0]), $past(op_second)});

    assert_call_push_R5: assert property (@(posedge clk) disable iff (rst)
        (step && op_first[7:3] == 5'b01101)
        |=> top == $past(pc_o) + PC_W'(2));

    assert_return_R9: assert property (@(posedge clk) disable iff (rst)
        (step && op_first == 8'h48) |=> pc_o == $past(top));

    assert_skip_set_R10: assert property (@(posedge clk) disable iff (rst)
        (step && op_first == 8'h49) |=> skip_o);

    assert_indirect_R11: assert property (@(posedge clk) disable iff (rst)
        (step && op_first == 8'hFF)
        |=> pc_o == {$past(pc_o[10:8]), $past(ind_byte)});

    assert_skip_clear_R12: assert property (@(posedge clk) disable iff (rst)
        (step && op_first != 8'h49) |=> !skip_o);

endmodule

bind pcu_ctrl pcu_ctrl_chk #(.STACK_DEPTH(STACK_DEPTH)) u_chk (.*);

// File: tb/pcu_ctrl_tb.sv
`timescale 1ns/1ps
module pcu_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        step;
    logic [7:0]  op_first, op_second, ind_byte;
    logic [10:0] pc_o;
    logic        skip_o;
    logic [32:0] stack_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [10:0] m_pc;
    logic [10:0] m_stk [3];
    logic        m_skip;

    always #2.5 clk = ~clk;

    pcu_ctrl u_dut (
        .clk(clk), .rst(rst), .step(step), .op_first(op_first),
        .op_second(op_second), .ind_byte(ind_byte),
        .pc_o(pc_o), .skip_o(skip_o), .stack_o(stack_o)
    );

    // Requirement tag for an opcode at a given counter value.
    function automatic string tag_of(input logic [7:0] op, input logic [10:0] pc);
        bit wide = (pc[10:7] == 4'b0001);
        if (op == 8'hFF)               return "R11";
        if (op == 8'h48)               return "R9";
        if (op == 8'h49)               return "R10";
        if (op[7:3] == 5'b01100)       return "R4";
        if (op[7:3] == 5'b01101)       return "R5";
        if (op[7] && wide)             return "R6";
        if (op[7] && op[6])            return "R7";
        if (op[7])                     return "R8";
        return "R2";
    endfunction

    function automatic logic [32:0] m_flat();
        return {m_stk[2], m_stk[1], m_stk[0]};
    endfunction

    task automatic m_push(input logic [10:0] v);
        m_stk[2] = m_stk[1];
        m_stk[1] = m_stk[0];
        m_stk[0] = v;
    endtask

    task automatic model_step(input logic [7:0] a, input logic [7:0] b, input logic [7:0] ind);
        string t = tag_of(a, m_pc);
        logic [10:0] nx;
        m_skip = 1'b0;
        if (t == "R11")      nx = {m_pc[10:8], ind};
        else if (t == "R9" || t == "R10") begin
            nx = m_stk[0];
            m_stk[0] = m_stk[1];
            m_stk[1] = m_stk[2];
            m_skip = (t == "R10");
        end
        else if (t == "R4")  nx = {a[2:0], b};
        else if (t == "R5")  begin nx = {a[2:0], b}; m_push(m_pc + 11'd2); end
        else if (t == "R6")  nx = {m_pc[10:7], a[6:0]};
        else if (t == "R7")  nx = {m_pc[10:6], a[5:0]};
        else if (t == "R8")  begin nx = 11'h080 | {5'd0, a[5:0]}; m_push(m_pc + 11'd1); end
        else                 nx = m_pc + 11'd1;
        m_pc = nx;
    endtask

    task automatic compare(input string t, input string skip_tag);
        vectors++;
        if (pc_o !== m_pc || stack_o !== m_flat()) begin
            fails++;
            $display("FAIL %s: pc=%h stack=%h expected pc=%h stack=%h",
                     t, pc_o, stack_o, m_pc, m_flat());
        end
        if (skip_o !== m_skip) begin
            fails++;
            $display("FAIL %s: skip=%b expected %b", skip_tag, skip_o, m_skip);
        end
    endtask

    task automatic exec(input logic [7:0] a, input logic [7:0] b, input logic [7:0] ind);
        string t = tag_of(a, m_pc);
        @(negedge clk);
        step = 1'b1; op_first = a; op_second = b; ind_byte = ind;
        model_step(a, b, ind);
        @(posedge clk); #1;
        step = 1'b0;
        compare(t, (a == 8'h49) ? "R10" : "R12");
    endtask

    task automatic idle(input logic [7:0] a);
        @(negedge clk);
        step = 1'b0; op_first = a; op_second = 8'hA5; ind_byte = 8'h5A;
        @(posedge clk); #1;
        compare("R3", "R3");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        step = 0; op_first = 0; op_second = 0; ind_byte = 0;
        rst = 1;
        @(negedge clk); @(negedge clk);
        // R1: reset state
        m_pc = 0; m_stk[0] = 0; m_stk[1] = 0; m_stk[2] = 0; m_skip = 0;
        compare("R1", "R1");
        @(negedge clk); rst = 0;

        // R2 sequential, R3 hold
        exec(8'h05, 8'h00, 8'h00);
        idle(8'h68);
        exec(8'h44, 8'h00, 8'h00);
        // R4 to 0x7FF, then R2 wrap to 0x000
        exec(8'h67, 8'hFF, 8'h00);
        exec(8'h00, 8'h00, 8'h00);
        // R5 call from 0x7FE wraps return to 0x000
        exec(8'h67, 8'hFE, 8'h00);
        exec(8'h68, 8'h40, 8'h00);
        // R7 on page 1 boundary 0x07F -> in-page
        exec(8'h60, 8'h7F, 8'h00);
        exec(8'hC3, 8'h00, 8'h00);
        // R8 short call from page 1
        exec(8'h9A, 8'h00, 8'h00);
        // R6 on pages 2/3, including 0x0FF
        exec(8'hA1, 8'h00, 8'h00);
        exec(8'h60, 8'hFF, 8'h00);
        exec(8'h81, 8'h00, 8'h00);
        // R11 priority on page 2 and on page 4
        exec(8'hFF, 8'h00, 8'h3C);
        exec(8'h61, 8'h00, 8'h00);
        exec(8'hBE, 8'h00, 8'h00);   // R8 at 0x100
        exec(8'h61, 8'h20, 8'h00);
        exec(8'hFF, 8'h00, 8'hE7);
        // R5 four deep: oldest dropped
        exec(8'h6A, 8'h11, 8'h00);
        exec(8'h6B, 8'h22, 8'h00);
        exec(8'h6C, 8'h33, 8'h00);
        exec(8'h6D, 8'h44, 8'h00);
        // R9 returns: level 2 keeps its value
        exec(8'h48, 8'h00, 8'h00);
        exec(8'h48, 8'h00, 8'h00);
        // R10 skip set, held when idle, cleared by next step (R12)
        exec(8'h49, 8'h00, 8'h00);
        idle(8'h00);
        exec(8'h49, 8'h00, 8'h00);
        exec(8'h00, 8'h00, 8'h00);

        for (int i = 0; i < 600; i++) begin
            logic [7:0] a, b, ind;
            int sel = $urandom_range(0, 9);
            b = 8'($urandom); ind = 8'($urandom);
            case (sel)
                0: a = {5'b01100, 3'($urandom)};
                1: a = {5'b01101, 3'($urandom)};
                2: a = {2'b10, 6'($urandom)};
                3: a = {2'b11, 6'($urandom)};
                4: a = 8'h48;
                5: a = 8'h49;
                6: a = 8'hFF;
                7: a = {5'b01100, 3'b000};
                default: a = 8'($urandom);
            endcase
            if ($urandom_range(0, 7) == 0) idle(a);
            else exec(a, b, ind);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule